// File: doc/BRIEF.md
# Single-Pass Arithmetic-Coder Renormalizer

This block rescales the state of a binary arithmetic encoder after each coded bin in one pass rather than in a loop of subtract-and-shift steps. It takes the 9-bit interval width and the 10-bit code base produced by the coding stage. The first pipeline stage counts the leading zeros of the width and shifts it up until its top bit is set. From the same count it forms the next code base, so that the next bin can be coded one cycle after this one is presented.

The second stage reads the window of code-base bits that the shift pushed out. It turns them into one symbol slot per rescaling step. Each slot holds either a definite bit or a bit whose value waits on a later decision. The stage resolves every waiting run that a later definite bit in the same window settles. It reports the one trailing run that stays open by its first and last slot. An input flag says that the packing logic downstream already holds an open run. When that flag is set, the first definite slot of the window also settles that run. The block reports the settling value so the packer can rewrite its held bits.

Top module: `shift_renorm`

## Requirements
- R1: For an accepted width w (legal values 2 to 511), `range_out` one cycle later equals w shifted left by n, where n is the count of leading zeros of w in 9 bits (0 to 7). Bit 8 of `range_out` is then 1.
- R2: Bits 8..0 of `low_out` equal bits 8..0 of the input code base shifted left by n.
- R3: Bit 9 of `low_out` is 1 only when input code-base bits 9 down to 9−n are all 1, and is 0 otherwise.
- R4: When n is 0, `low_out` equals the input code base. In the matching parse result, `sym_count` is 0, `sym_bits` is 0, and both `pend_flag` and `carry_flag` are 0.
- R5: `sym_valid` rises one cycle after `upd_valid`, and `sym_count` then equals n.
- R6: Window position p is input code-base bit 9−p, for p = 0..7. Slot k (k < n) is decided by the window as follows:
  - If positions 0..k are all 1, the slot is a definite 1.
  - Otherwise, if position k+1 is 1, the slot is waiting.
  - Otherwise, the slot is a definite 0.
  - `sym_bits[k]` holds slot k. A waiting run that a later definite slot settles reads as 0 on its first slot and 1 on the rest. The definite slot that settles it reads 1.
  - Slots at or above n, and waiting slots left open, read 0.
- R7: When the window ends in waiting slots that nothing settles, `pend_flag` is 1, `pend_first` is the first such slot, and `pend_last` is n−1. Otherwise all three are 0.
- R8: With `tail_pend_in` set and at least one definite slot present, `carry_flag` is 1 and `carry_bit` gives that slot's definite value. Every slot up to and including that first definite slot then reads the complement of `carry_bit`. With the flag clear, `carry_flag` and `carry_bit` are 0.
- R9: Cycles with `in_valid` low change no data output, and drop `upd_valid`, then `sym_valid`, one cycle apart. Inputs may be presented on back-to-back cycles.
- R10: While `rst` is high, and after it, until the first accepted input, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Width, base and flag are presented this cycle |
| range_in | input | 9 | Interval width from the coding stage |
| low_in | input | 10 | Code base from the coding stage |
| tail_pend_in | input | 1 | Packer currently holds an open waiting run |
| upd_valid | output | 1 | Rescaled state is valid |
| range_out | output | 9 | Rescaled interval width |
| low_out | output | 10 | Rescaled code base |
| sym_valid | output | 1 | Parse result is valid |
| sym_count | output | 3 | Number of symbol slots (n) |
| sym_bits | output | 7 | Slot values, slot 0 in bit 0 |
| pend_flag | output | 1 | A trailing waiting run is still open |
| pend_first | output | 3 | First slot of the open run |
| pend_last | output | 3 | Last slot of the open run |
| carry_flag | output | 1 | The packer's held run is settled by this window |
| carry_bit | output | 1 | Value that settles the held run |

## Verification
On every cycle, the in-line assertions check several properties:
- the accepted width is within its legal range;
- the rescaled width is normalized;
- idle cycles keep the state still;
- no slot at or above the count carries a bit;
- an open run starts no later than it ends;
- a settling report only follows a set tail flag;
- an empty window reports nothing.

The actual slot values cannot be captured as a cycle-local property. The same holds for the exact split of the code base, and for the way runs resolve across the window and into the packer's held run. The bench's scenarios cover these. They compare every window position pattern, at every shift count and both flag values, against a step-by-step model of the loop and of bit emission with deferred runs.

// File: rtl/shift_renorm_pkg.sv
package shift_renorm_pkg;
  // classification of one rescaling step
  typedef enum logic [1:0] {
    SLOT_ZERO = 2'd0,
    SLOT_ONE  = 2'd1,
    SLOT_OPEN = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/rn_lzc.sv
module rn_lzc #(
  parameter int W    = 9,
  parameter int MAXC = 7,
  parameter int CW   = $clog2(MAXC + 1)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  int   zeros_c;
  logic hit_c;

  always_comb begin
    zeros_c = 0;
    hit_c   = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit_c) begin
        if (val_i[i]) hit_c = 1'b1;
        else          zeros_c = zeros_c + 1;
      end
    end
    if (zeros_c > MAXC) zeros_c = MAXC;
    cnt_o = CW'(zeros_c);
  end
endmodule

// File: rtl/rn_low_stage.sv
module rn_low_stage #(
  parameter int RANGE_W  = 9,
  parameter int LOW_W    = RANGE_W + 1,
  parameter int MAX_ITER = RANGE_W - 2,
  parameter int CW       = $clog2(MAX_ITER + 1),
  parameter int WIN_W    = MAX_ITER + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid_i,
  input  logic [RANGE_W-1:0] range_i,
  input  logic [LOW_W-1:0]   low_i,
  input  logic               tail_i,
  output logic               valid_o,
  output logic [RANGE_W-1:0] range_o,
  output logic [LOW_W-1:0]   low_o,
  output logic [CW-1:0]      iter_o,
  output logic [WIN_W-1:0]   win_o,
  output logic               tail_o
);
  logic [CW-1:0]      iter_c;
  logic [RANGE_W-1:0] range_next;
  logic [LOW_W-2:0]   low_rest;
  logic               keep_top;
  logic [WIN_W-1:0]   win_c;

  rn_lzc #(.W(RANGE_W), .MAXC(MAX_ITER), .CW(CW)) u_lzc (
    .val_i (range_i),
    .cnt_o (iter_c)
  );

  assign range_next = range_i << iter_c;
  assign low_rest   = low_i[LOW_W-2:0] << iter_c;

  // top bit survives only if the whole run down to the new top was ones
  always_comb begin
    keep_top = 1'b1;
    for (int k = 0; k < WIN_W; k++) begin
      if (k <= int'(iter_c)) keep_top = keep_top & low_i[LOW_W-1-k];
    end
  end

  for (genvar p = 0; p < WIN_W; p++) begin : g_win
    assign win_c[p] = low_i[LOW_W-1-p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      range_o <= '0;
      low_o   <= '0;
      iter_o  <= '0;
      win_o   <= '0;
      tail_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        range_o <= range_next;
        low_o   <= {keep_top, low_rest};
        iter_o  <= iter_c;
        win_o   <= win_c;
        tail_o  <= tail_i;
      end
    end
  end

  AST_IN_CONTRACT: assert property (@(posedge clk) disable iff (rst)
    valid_i |-> (range_i >= RANGE_W'(2))); // R1
  AST_NORMALIZED: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> range_o[RANGE_W-1]); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(range_o) && $stable(low_o))); // R9
endmodule

// File: rtl/rn_parse.sv
module rn_parse
  import shift_renorm_pkg::*;
#(
  parameter int MAX_ITER = 7,
  parameter int CW       = $clog2(MAX_ITER + 1),
  parameter int WIN_W    = MAX_ITER + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic [CW-1:0]       iter_i,
  input  logic [WIN_W-1:0]    win_i,
  input  logic                tail_i,
  output logic                valid_o,
  output logic [CW-1:0]       nsym_o,
  output logic [MAX_ITER-1:0] bits_o,
  output logic                pend_o,
  output logic [CW-1:0]       pend_first_o,
  output logic [CW-1:0]       pend_last_o,
  output logic                carry_o,
  output logic                carry_bit_o
);
  logic [MAX_ITER-1:0] act, lead, open, prev_open, resolved, bit_c;
  slot_kind_e          kind [MAX_ITER];
  logic                seen, any_def, pend_c, carry_c;
  logic [CW-1:0]       first_c;

  for (genvar k = 0; k < MAX_ITER; k++) begin : g_slot
    assign act[k] = (iter_i > CW'(k));
    if (k == 0) begin : g_head
      assign lead[k] = win_i[0];
    end else begin : g_body
      assign lead[k] = lead[k-1] & win_i[k];
    end
    assign kind[k] = lead[k]     ? SLOT_ONE  :
                     win_i[k+1]  ? SLOT_OPEN : SLOT_ZERO;
    assign open[k] = act[k] && (kind[k] == SLOT_OPEN);
  end

  // slot before slot 0 is the packer's held run
  assign prev_open = {open[MAX_ITER-2:0], tail_i};

  // a waiting slot is settled by any later definite slot
  always_comb begin
    seen = 1'b0;
    for (int k = MAX_ITER - 1; k >= 0; k--) begin
      resolved[k] = seen;
      if (act[k] && (kind[k] != SLOT_OPEN)) seen = 1'b1;
    end
    any_def = seen;
  end

  always_comb begin
    for (int k = 0; k < MAX_ITER; k++) begin
      if (!act[k])                 bit_c[k] = 1'b0;
      else if (kind[k] == SLOT_OPEN) bit_c[k] = resolved[k] & prev_open[k];
      else                         bit_c[k] = lead[k] ^ prev_open[k];
    end
  end

  always_comb begin
    pend_c  = 1'b0;
    first_c = '0;
    for (int k = MAX_ITER - 1; k >= 0; k--) begin
      if (open[k] && !resolved[k]) begin
        pend_c  = 1'b1;
        first_c = CW'(k);
      end
    end
  end

  assign carry_c = tail_i & any_def;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o      <= 1'b0;
      nsym_o       <= '0;
      bits_o       <= '0;
      pend_o       <= 1'b0;
      pend_first_o <= '0;
      pend_last_o  <= '0;
      carry_o      <= 1'b0;
      carry_bit_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        nsym_o       <= iter_i;
        bits_o       <= bit_c;
        pend_o       <= pend_c;
        pend_first_o <= first_c;
        pend_last_o  <= pend_c ? (iter_i - CW'(1)) : '0;
        carry_o      <= carry_c;
        carry_bit_o  <= carry_c & lead[0];
      end
    end
  end

  AST_EMPTY_SLOTS: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> ((bits_o >> nsym_o) == '0)); // R6
  AST_PEND_ORDER: assert property (@(posedge clk) disable iff (rst)
    (valid_o && pend_o) |-> (pend_first_o <= pend_last_o)); // R7
  AST_CARRY_NEEDS_TAIL: assert property (@(posedge clk) disable iff (rst)
    (valid_o && carry_o) |-> $past(tail_i)); // R8
  AST_NOSYM_QUIET: assert property (@(posedge clk) disable iff (rst)
    (valid_o && nsym_o == '0) |-> (!pend_o && !carry_o && bits_o == '0)); // R4
endmodule

// File: rtl/shift_renorm.sv
module shift_renorm #(
  parameter  int RANGE_W  = 9,
  localparam int LOW_W    = RANGE_W + 1,
  localparam int MAX_ITER = RANGE_W - 2,
  localparam int WIN_W    = MAX_ITER + 1,
  localparam int CW       = $clog2(MAX_ITER + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [RANGE_W-1:0]  range_in,
  input  logic [LOW_W-1:0]    low_in,
  input  logic                tail_pend_in,
  output logic                upd_valid,
  output logic [RANGE_W-1:0]  range_out,
  output logic [LOW_W-1:0]    low_out,
  output logic                sym_valid,
  output logic [CW-1:0]       sym_count,
  output logic [MAX_ITER-1:0] sym_bits,
  output logic                pend_flag,
  output logic [CW-1:0]       pend_first,
  output logic [CW-1:0]       pend_last,
  output logic                carry_flag,
  output logic                carry_bit
);
  logic [CW-1:0]    s1_iter;
  logic [WIN_W-1:0] s1_win;
  logic             s1_tail;

  rn_low_stage #(
    .RANGE_W(RANGE_W), .LOW_W(LOW_W), .MAX_ITER(MAX_ITER), .CW(CW), .WIN_W(WIN_W)
  ) u_low (
    .clk     (clk),
    .rst     (rst),
    .valid_i (in_valid),
    .range_i (range_in),
    .low_i   (low_in),
    .tail_i  (tail_pend_in),
    .valid_o (upd_valid),
    .range_o (range_out),
    .low_o   (low_out),
    .iter_o  (s1_iter),
    .win_o   (s1_win),
    .tail_o  (s1_tail)
  );

  rn_parse #(.MAX_ITER(MAX_ITER), .CW(CW), .WIN_W(WIN_W)) u_parse (
    .clk          (clk),
    .rst          (rst),
    .valid_i      (upd_valid),
    .iter_i       (s1_iter),
    .win_i        (s1_win),
    .tail_i       (s1_tail),
    .valid_o      (sym_valid),
    .nsym_o       (sym_count),
    .bits_o       (sym_bits),
    .pend_o       (pend_flag),
    .pend_first_o (pend_first),
    .pend_last_o  (pend_last),
    .carry_o      (carry_flag),
    .carry_bit_o  (carry_bit)
  );

  AST_STAGE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> sym_valid); // R5
  AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> !sym_valid); // R9
endmodule

// File: tb/shift_renorm_test.sv
module shift_renorm_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       in_valid = 1'b0;
  logic [8:0] range_in = '0;
  logic [9:0] low_in = '0;
  logic       tail_pend_in = 1'b0;
  logic       upd_valid, sym_valid, pend_flag, carry_flag, carry_bit;
  logic [8:0] range_out;
  logic [9:0] low_out;
  logic [2:0] sym_count, pend_first, pend_last;
  logic [6:0] sym_bits;

  shift_renorm uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .range_in(range_in),
    .low_in(low_in), .tail_pend_in(tail_pend_in), .upd_valid(upd_valid),
    .range_out(range_out), .low_out(low_out), .sym_valid(sym_valid),
    .sym_count(sym_count), .sym_bits(sym_bits), .pend_flag(pend_flag),
    .pend_first(pend_first), .pend_last(pend_last), .carry_flag(carry_flag),
    .carry_bit(carry_bit)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct packed {
    logic [8:0] rng;
    logic [9:0] low;
    logic [2:0] n;
    logic [6:0] bits;
    logic       pend;
    logic [2:0] ps;
    logic [2:0] pe;
    logic       carry;
    logic       cbit;
  } exp_t;

  // step-by-step loop plus deferred-run bit emission
  function automatic exp_t model(int rng, int lw, bit tl);
    exp_t e;
    int r = rng;
    int l = lw;
    int n = 0;
    int sy[8];
    int st[9];
    int wr = 0;
    int p0 = tl ? 1 : 0;
    int pnd = p0;
    int start;
    e = '0;
    while (r < 256 && n < 8) begin
      if (l < 256) sy[n] = 0;
      else if (l >= 512) begin l -= 512; sy[n] = 1; end
      else begin l -= 256; sy[n] = 2; end
      r = r << 1;
      l = l << 1;
      n++;
    end
    for (int i = 0; i < n; i++) begin
      if (sy[i] == 2) pnd++;
      else begin
        st[wr] = sy[i]; wr++;
        for (int j = 0; j < pnd; j++) begin st[wr] = 1 - sy[i]; wr++; end
        pnd = 0;
      end
    end
    e.rng = r[8:0];
    e.low = l[9:0];
    e.n   = n[2:0];
    for (int k = 0; k < n; k++) if (p0 + k < wr) e.bits[k] = st[p0 + k][0];
    e.carry = tl && (wr > 0);
    e.cbit  = e.carry && (st[0] == 1);
    start = wr - p0;
    if (start < 0) start = 0;
    if (start < n) begin
      e.pend = 1'b1;
      e.ps   = start[2:0];
      e.pe   = 3'(n - 1);
    end
    return e;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_s1(exp_t e);
    chk("R1", "range_out", 32'(range_out), 32'(e.rng));
    chk("R2", "low_out[8:0]", 32'(low_out[8:0]), 32'(e.low[8:0]));
    chk("R3", "low_out[9]", 32'(low_out[9]), 32'(e.low[9]));
    chk("R9", "upd_valid", 32'(upd_valid), 32'd1);
  endtask

  task automatic check_p(exp_t e);
    chk("R5", "sym_valid", 32'(sym_valid), 32'd1);
    chk("R5", "sym_count", 32'(sym_count), 32'(e.n));
    chk("R6", "sym_bits", 32'(sym_bits), 32'(e.bits));
    chk("R7", "pend", 32'({pend_flag, pend_first, pend_last}), 32'({e.pend, e.ps, e.pe}));
    chk("R8", "carry", 32'({carry_flag, carry_bit}), 32'({e.carry, e.cbit}));
  endtask

  task automatic run_one(int r, int l, bit t, output exp_t e);
    e = model(r, l, t);
    @(negedge clk);
    in_valid = 1'b1; range_in = r[8:0]; low_in = l[9:0]; tail_pend_in = t;
    @(posedge clk); #1;
    check_s1(e);
    @(negedge clk);
    in_valid = 1'b0;
    @(posedge clk); #1;
    check_p(e);
    if (e.n == 3'd0) begin
      chk("R4", "low passthrough", 32'(low_out), 32'(l));
      chk("R4", "empty window", 32'({sym_bits, pend_flag, carry_flag}), 32'd0);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "outputs in reset", 32'({upd_valid, sym_valid, range_out, low_out}), 32'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R10", "parse outputs after reset",
        32'({sym_count, sym_bits, pend_flag, pend_first, pend_last, carry_flag, carry_bit}), 32'd0);
  endtask

  task automatic t_range_sweep;
    exp_t e;
    for (int r = 2; r < 512; r++) run_one(r, (r * 7) % 1024, r[0], e);
  endtask

  task automatic t_all_windows;
    exp_t e;
    for (int it = 0; it < 8; it++)
      for (int lw = 0; lw < 1024; lw++)
        for (int tl = 0; tl < 2; tl++)
          run_one((256 >> it) | (it == 0 ? 37 : 1), lw, tl[0], e);
  endtask

  task automatic t_hand_cases;
    exp_t e;
    // two waiting slots left open: R7
    run_one(9'h040, 10'h180, 1'b0, e);
    chk("R7", "hand open run", 32'({pend_flag, pend_first, pend_last}), 32'({1'b1, 3'd0, 3'd1}));
    chk("R2", "hand low", 32'(low_out), 32'h000);
    // three leading ones: R6
    run_one(9'h020, 10'h3A0, 1'b0, e);
    chk("R6", "hand leading ones", 32'(sym_bits), 32'h07);
    chk("R3", "hand low", 32'(low_out), 32'h100);
    // held run settled by a one: R8
    run_one(9'h080, 10'h200, 1'b1, e);
    chk("R8", "hand carry", 32'({carry_flag, carry_bit, sym_bits}), 32'({1'b1, 1'b1, 7'h00}));
  endtask

  task automatic t_idle_hold;
    exp_t e;
    run_one(9'h011, 10'h2D6, 1'b1, e);
    @(negedge clk);
    range_in = 9'h1FF; low_in = 10'h3FF; tail_pend_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "valids low when idle", 32'({upd_valid, sym_valid}), 32'd0);
    chk("R9", "state held", 32'({range_out, low_out}), 32'({e.rng, e.low}));
    chk("R9", "parse held", 32'({sym_count, sym_bits, pend_flag, carry_flag}),
        32'({e.n, e.bits, e.pend, e.carry}));
  endtask

  task automatic t_back_to_back;
    exp_t q[4];
    int rv[4] = '{9'h003, 9'h0C0, 9'h100, 9'h021};
    int lv[4] = '{10'h155, 10'h2FF, 10'h0AA, 10'h1C3};
    for (int i = 0; i < 4; i++) q[i] = model(rv[i], lv[i], i[0]);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i < 4) begin
        in_valid = 1'b1; range_in = rv[i][8:0]; low_in = lv[i][9:0]; tail_pend_in = i[0];
      end else in_valid = 1'b0;
      @(posedge clk); #1;
      if (i < 4) check_s1(q[i]);
      if (i > 0) check_p(q[i-1]);
    end
    @(negedge clk);
    @(posedge clk); #1;
    chk("R9", "pipeline drained", 32'({upd_valid, sym_valid}), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_hand_cases();
    t_idle_hold();
    t_back_to_back();
    t_range_sweep();
    t_all_windows();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule